// File: doc/BRIEF.md
# Half-Word to Word Register Access Adapter

This adapter lets a master with a 16-bit data path reach a block of 32-bit registers without tearing values that change between accesses, such as a free-running counter. Each 32-bit register is seen as two half-words: address bit 1 picks the upper half when set and the lower half when clear.

Writes are combined. A lower-half write only loads a holding register. An upper-half write then issues a single 32-bit write made of the new upper data and the held lower data. Reads are split. A lower-half read performs the one real 32-bit read, returns the lower 16 bits and keeps the upper 16 bits in a read latch. A later upper-half read is served from that latch and does not touch the register block. Software therefore writes low then high, and reads low then high.

Byte-wide accesses are rejected. They raise an error pulse, return zero on reads and leave the register block and both internal half-word stores alone. The adapter does not decode registers itself. It presents the word address, the strobes and the data.

Top module: `hb_top`

## Requirements
- R1: After reset, hw_rdata_o, hw_rvalid_o and hw_err_o are 0, and the write holding register and the read latch are both zero. An upper read before any lower read returns 0, and an upper write before any lower write carries 16'h0000 in bits 15:0.
- R2: A half-word write with address bit 1 = 0 asserts no reg_we_o and only stores hw_wdata_i in the holding register.
- R3: A half-word write with address bit 1 = 1 asserts reg_we_o for exactly the request cycle, with reg_wdata_o = {hw_wdata_i, holding register}.
- R4: A half-word read with address bit 1 = 0 asserts reg_re_o in the request cycle. On the following cycle it gives hw_rvalid_o = 1 and hw_rdata_o = reg_rdata_i[15:0] as sampled at that clock edge.
- R5: A lower-half read stores reg_rdata_i[31:16] in the read latch. A read with address bit 1 = 1 asserts no reg_re_o and returns the latch value on the following cycle with hw_rvalid_o = 1.
- R6: An access with hw_byte_i = 1 asserts neither strobe and pulses hw_err_o for exactly the next cycle. If it is a read, it returns hw_rdata_o = 0 with hw_rvalid_o = 1. The holding register and the read latch are unchanged.
- R7: The holding register and the read latch are independent. Writes never change the read latch, and reads never change the holding register.
- R8: reg_addr_o equals hw_addr_i with bit 1 forced to 0, and reg_re_o and reg_we_o are never asserted together.
- R9: The holding register keeps its value across upper-half writes, so repeated upper writes reuse the same lower 16 bits.
- R10: The read latch keeps the upper half captured at the last lower read while reg_rdata_i keeps changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | 1 | Access request, one cycle per access |
| hw_we_i | input | 1 | 1 = write, 0 = read |
| hw_byte_i | input | 1 | 1 = byte-wide access (rejected) |
| hw_addr_i | input | AW | Half-word byte address; bit 1 selects the upper half |
| hw_wdata_i | input | 16 | Write data |
| hw_rdata_o | output | 16 | Read data, valid with hw_rvalid_o |
| hw_rvalid_o | output | 1 | Read response pulse |
| hw_err_o | output | 1 | Byte-access error pulse |
| reg_re_o | output | 1 | 32-bit register read strobe |
| reg_we_o | output | 1 | 32-bit register write strobe |
| reg_addr_o | output | AW | Word address (bit 1 cleared) |
| reg_wdata_o | output | 32 | 32-bit write data |
| reg_rdata_i | input | 32 | 32-bit read data, combinational from the register block |

## Verification
The register strobes, address and write data follow the request combinationally, so they are due in the request cycle itself. The read data, read-valid and error pulse are registered and appear one clock edge later. The bench drives each request on a falling edge and samples the combinational side shortly after. It then samples the registered side on the next falling edge, after the single intervening rising edge. The register model is a counter that advances every clock, and the value the adapter captures is the one the bench sees just before that rising edge.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WR_LO,
    OP_WR_HI,
    OP_RD_LO,
    OP_RD_HI,
    OP_BAD_WR,
    OP_BAD_RD
  } hb_op_e;
endpackage

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic          byte_i,
  input  logic [AW-1:0] addr_i,
  output hb_op_e        op_o,
  output logic [AW-1:0] word_addr_o
);
  logic hi_sel;
  assign hi_sel = addr_i[1];

  always_comb begin
    op_o = OP_IDLE;
    if (req_i) begin
      if (byte_i)      op_o = we_i ? OP_BAD_WR : OP_BAD_RD;
      else if (we_i)   op_o = hi_sel ? OP_WR_HI : OP_WR_LO;
      else             op_o = hi_sel ? OP_RD_HI : OP_RD_LO;
    end
  end

  always_comb begin
    word_addr_o    = addr_i;
    word_addr_o[1] = 1'b0;
  end
endmodule

// File: rtl/hb_wr_hold.sv
module hb_wr_hold
  import hb_pkg::*;
#(
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  hb_op_e        op_i,
  input  logic [HW-1:0] wdata_i,
  output logic          we_o,
  output logic [WW-1:0] wdata_o
);
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_q <= '0;
    else if (op_i == OP_WR_LO)  hold_q <= wdata_i;
  end

  assign we_o    = (op_i == OP_WR_HI);
  assign wdata_o = {wdata_i, hold_q};
endmodule

// File: rtl/hb_rd_resp.sv
module hb_rd_resp
  import hb_pkg::*;
#(
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  hb_op_e        op_i,
  input  logic [WW-1:0] reg_rdata_i,
  output logic          re_o,
  output logic [HW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          err_o
);
  logic [HW-1:0] upper_q;
  logic [HW-1:0] rdata_q;
  logic          rvalid_q;
  logic          err_q;
  logic [HW-1:0] rdata_d;

  assign re_o = (op_i == OP_RD_LO);

  always_comb begin
    unique case (op_i)
      OP_RD_LO: rdata_d = reg_rdata_i[HW-1:0];
      OP_RD_HI: rdata_d = upper_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (op_i == OP_RD_LO) upper_q <= reg_rdata_i[WW-1:HW];
      rdata_q  <= rdata_d;
      rvalid_q <= (op_i == OP_RD_LO) || (op_i == OP_RD_HI) || (op_i == OP_BAD_RD);
      err_q    <= (op_i == OP_BAD_RD) || (op_i == OP_BAD_WR);
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
endmodule

// File: rtl/hb_top.sv
module hb_top
  import hb_pkg::*;
#(
  parameter int AW = 8,
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hw_req_i,
  input  logic          hw_we_i,
  input  logic          hw_byte_i,
  input  logic [AW-1:0] hw_addr_i,
  input  logic [HW-1:0] hw_wdata_i,
  output logic [HW-1:0] hw_rdata_o,
  output logic          hw_rvalid_o,
  output logic          hw_err_o,
  output logic          reg_re_o,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [WW-1:0] reg_wdata_o,
  input  logic [WW-1:0] reg_rdata_i
);
  hb_op_e op;

  hb_decode #(.AW(AW)) u_decode (
    .req_i      (hw_req_i),
    .we_i       (hw_we_i),
    .byte_i     (hw_byte_i),
    .addr_i     (hw_addr_i),
    .op_o       (op),
    .word_addr_o(reg_addr_o)
  );

  hb_wr_hold #(.HW(HW)) u_wr_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .wdata_i(hw_wdata_i),
    .we_o   (reg_we_o),
    .wdata_o(reg_wdata_o)
  );

  hb_rd_resp #(.HW(HW)) u_rd_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .reg_rdata_i(reg_rdata_i),
    .re_o       (reg_re_o),
    .rdata_o    (hw_rdata_o),
    .rvalid_o   (hw_rvalid_o),
    .err_o      (hw_err_o)
  );
endmodule

// File: rtl/hb_chk.sv
module hb_chk #(
  parameter int AW = 8,
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hw_req_i,
  input logic          hw_we_i,
  input logic          hw_byte_i,
  input logic [AW-1:0] hw_addr_i,
  input logic [HW-1:0] hw_wdata_i,
  input logic [HW-1:0] hw_rdata_o,
  input logic          hw_rvalid_o,
  input logic          hw_err_o,
  input logic          reg_re_o,
  input logic          reg_we_o,
  input logic [AW-1:0] reg_addr_o,
  input logic [WW-1:0] reg_wdata_o,
  input logic [WW-1:0] reg_rdata_i
);
  logic good_req;
  assign good_req = hw_req_i && !hw_byte_i;

  // R2
  wr_lo_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_req && hw_we_i && !hw_addr_i[1]) |-> !reg_we_o);

  // R3
  wr_hi_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_req && hw_we_i && hw_addr_i[1]) |-> (reg_we_o && reg_wdata_o[WW-1:HW] == hw_wdata_i));

  // R3
  we_only_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (good_req && hw_we_i));

  // R4
  rd_lo_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_req && !hw_we_i && !hw_addr_i[1]) |=> (hw_rvalid_o && hw_rdata_o == $past(reg_rdata_i[HW-1:0])));

  // R5
  rd_hi_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_req && !hw_we_i && hw_addr_i[1]) |-> (!reg_re_o ##1 hw_rvalid_o));

  // R6
  byte_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_req_i && hw_byte_i) |-> (!reg_re_o && !reg_we_o));

  // R6
  byte_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_req_i && hw_byte_i) |=> hw_err_o);

  // R6
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hw_req_i && hw_byte_i) |=> !hw_err_o);

  // R8
  addr_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_o || reg_we_o) |-> (!reg_addr_o[1] && reg_addr_o[AW-1:2] == hw_addr_i[AW-1:2] && reg_addr_o[0] == hw_addr_i[0]));

  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_re_o, reg_we_o}));
endmodule

bind hb_top hb_chk #(.AW(AW), .HW(HW)) u_chk (.*);

// File: tb/hb_top_tb.sv
module hb_top_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, byt = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          rvalid, err, re_s, we_s;
  logic [AW-1:0] raddr;
  logic [31:0]   rwdata;
  logic [31:0]   cnt;

  int checks = 0;
  int fails  = 0;

  logic          s_re, s_we;
  logic [AW-1:0] s_addr;
  logic [31:0]   s_wdata, s_rdin;
  logic [15:0]   r_rdata;
  logic          r_rvalid, r_err;
  logic [15:0]   upper_exp;

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 32'h1357_0000;
    else        cnt <= cnt + 32'h0001_2345;
  end

  hb_top #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .hw_req_i(req), .hw_we_i(we), .hw_byte_i(byt),
    .hw_addr_i(addr), .hw_wdata_i(wdata),
    .hw_rdata_o(rdata), .hw_rvalid_o(rvalid), .hw_err_o(err),
    .reg_re_o(re_s), .reg_we_o(we_s), .reg_addr_o(raddr),
    .reg_wdata_o(rwdata), .reg_rdata_i(cnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic access(input logic w, input logic b, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = w; byt = b; addr = a; wdata = d;
    #1;
    s_re = re_s; s_we = we_s; s_addr = raddr; s_wdata = rwdata; s_rdin = cnt;
    @(negedge clk);
    req = 1'b0; we = 1'b0; byt = 1'b0;
    r_rdata = rdata; r_rvalid = rvalid; r_err = err;
  endtask

  task automatic t_reset;
    chk("R1 rdata", {16'h0, rdata}, 32'h0);
    chk("R1 rvalid", {31'h0, rvalid}, 32'h0);
    chk("R1 err", {31'h0, err}, 32'h0);
    access(1'b0, 1'b0, 8'h06, 16'h0);
    chk("R1 latch zero", {16'h0, r_rdata}, 32'h0);
    access(1'b1, 1'b0, 8'h06, 16'hABCD);
    chk("R1 hold zero", s_wdata, 32'hABCD_0000);
  endtask

  task automatic t_writes;
    access(1'b1, 1'b0, 8'h10, 16'h1234);
    chk("R2 no write", {31'h0, s_we}, 32'h0);
    access(1'b1, 1'b0, 8'h12, 16'h5678);
    chk("R3 strobe", {31'h0, s_we}, 32'h1);
    chk("R3 data", s_wdata, 32'h5678_1234);
    chk("R8 wr addr", {24'h0, s_addr}, 32'h10);
    @(negedge clk);
    chk("R3 single pulse", {31'h0, we_s}, 32'h0);
    access(1'b1, 1'b0, 8'h12, 16'h9ABC);
    chk("R9 hold reused", s_wdata, 32'h9ABC_1234);
  endtask

  task automatic t_reads;
    access(1'b0, 1'b0, 8'h25, 16'h0);
    upper_exp = s_rdin[31:16];
    chk("R4 strobe", {31'h0, s_re}, 32'h1);
    chk("R8 rd addr", {24'h0, s_addr}, 32'h25);
    chk("R4 data", {16'h0, r_rdata}, {16'h0, s_rdin[15:0]});
    chk("R4 rvalid", {31'h0, r_rvalid}, 32'h1);
    idle(5);
    access(1'b0, 1'b0, 8'h27, 16'h0);
    chk("R5 no strobe", {31'h0, s_re}, 32'h0);
    chk("R10 latched upper", {16'h0, r_rdata}, {16'h0, upper_exp});
    chk("R5 rvalid", {31'h0, r_rvalid}, 32'h1);
  endtask

  task automatic t_byte;
    access(1'b0, 1'b1, 8'h24, 16'h0);
    chk("R6 rd strobe", {30'h0, s_re, s_we}, 32'h0);
    chk("R6 rdata zero", {16'h0, r_rdata}, 32'h0);
    chk("R6 rvalid", {31'h0, r_rvalid}, 32'h1);
    chk("R6 err", {31'h0, r_err}, 32'h1);
    @(negedge clk);
    chk("R6 err one cycle", {31'h0, err}, 32'h0);
    access(1'b1, 1'b1, 8'h10, 16'hEEEE);
    chk("R6 wr strobe", {30'h0, s_re, s_we}, 32'h0);
    chk("R6 wr err", {31'h0, r_err}, 32'h1);
    access(1'b0, 1'b0, 8'h27, 16'h0);
    chk("R6 latch kept", {16'h0, r_rdata}, {16'h0, upper_exp});
    access(1'b1, 1'b0, 8'h12, 16'h0001);
    chk("R6 hold kept", s_wdata, 32'h0001_1234);
  endtask

  task automatic t_indep;
    access(1'b1, 1'b0, 8'h30, 16'h0F0F);
    access(1'b0, 1'b0, 8'h32, 16'h0);
    chk("R7 latch after write", {16'h0, r_rdata}, {16'h0, upper_exp});
    access(1'b0, 1'b0, 8'h30, 16'h0);
    upper_exp = s_rdin[31:16];
    access(1'b1, 1'b0, 8'h32, 16'h7777);
    chk("R7 hold after read", s_wdata, 32'h7777_0F0F);
    access(1'b0, 1'b0, 8'h32, 16'h0);
    chk("R7 latch after hi write", {16'h0, r_rdata}, {16'h0, upper_exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_writes();
    t_reads();
    t_byte();
    t_indep();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule